// File: doc/BRIEF.md
# Reset Supervisor with Filtered Manual Reset

This block generates the system reset for a processor subsystem. It merges two reset causes into one stretched reset output. The first cause is a digital supply-good flag that comes from an external voltage comparator. The second is an active-low manual reset line, typically a push button or another device's output. The block asserts reset while either cause is present. After the last cause clears, it keeps reset asserted for a fixed hold time, so the supply and the processor can settle.

Both inputs are asynchronous, so each passes through a two-flop synchronizer. The manual line then goes through a saturating-counter filter. The filter ignores short glitches and switch bounce, and it only accepts a level that stays steady for the accept time. The hold time and the accept time are given in physical units and converted to clock cycles from the clock-frequency parameter. A parameter selects the output polarity. A one-cycle pulse marks each release of reset, for sequencing logic further down the chip.

Top module: `rst_supervisor`

## Requirements
- R1: Reset is asserted while `supply_ok` is low; a low level sampled at clock edge K shows on the output after edge K+2 (two synchronizer stages, then the hold register).
- R2: Reset stays asserted for as long as the filtered manual reset is active, however long that lasts.
- R3: Once the last cause clears, reset stays asserted for exactly HOLD_CYC more cycles. After `supply_ok` rises before edge K, with no manual reset, the output first reads inactive after edge K+1+HOLD_CYC.
- R4: When `por_n` is low, reset is asserted and the hold counter is loaded. After `por_n` is released, the full hold time always runs, whether `supply_ok` is already high or rises later.
- R5: Any new occurrence of either cause, including one during the hold time, reloads the full HOLD_CYC count.
- R6: A low pulse on `mr_n` that lasts fewer than MR_CYC cycles is ignored and does not assert reset.
- R7: The manual reset becomes active after MR_CYC consecutive low samples. It goes inactive only after MR_CYC consecutive high samples, and any low sample restarts that count.
- R8: With OUT_ACTIVE_HIGH = 0, the asserted level of `rst_out` is 0. With OUT_ACTIVE_HIGH = 1, it is 1.
- R9: `rst_release` is high for exactly one cycle: the first cycle in which reset reads inactive.
- R10: If `mr_n` is held high (unused), it never causes a reset.

HOLD_CYC = ceil(CLK_HZ × HOLD_US / 10^6) and MR_CYC = ceil(CLK_HZ × MR_FILTER_NS / 10^9). Each value is at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Synchronous active-low power-on initialisation |
| supply_ok | input | 1 | Asynchronous supply-good flag from the comparator; high means the supply is above threshold |
| mr_n | input | 1 | Asynchronous active-low manual reset; tie high when unused |
| rst_out | output | 1 | Stretched reset; its polarity is set by OUT_ACTIVE_HIGH |
| rst_release | output | 1 | One-cycle pulse in the first cycle after reset is released |

## Verification
The assertions assume that `por_n` is held low across at least one clock edge before the first checked cycle. They also assume that `supply_ok` and `mr_n` reach the logic only through the synchronizer, so a property can relate the synchronized levels to the hold register one cycle later. The stimulus holds `por_n` low for several edges at start-up. It changes the asynchronous inputs only on falling clock edges, so every change lands in a known synchronizer stage and the expected latencies can be counted exactly. Pulse widths are chosen just below and just above MR_CYC to exercise both sides of the filter threshold.

// File: rtl/rst_supervisor_pkg.sv
// Package: rst_supervisor_pkg
// Helper for turning physical times into clock-cycle counts.
// Assumes: the clock frequency is given in Hz; results are rounded up and
// are at least one cycle.
package rst_supervisor_pkg;

    // Convert a time in nanoseconds to a whole number of clock cycles (ceiling, min 1)
    function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                                 input longint unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = hz * ns;
        cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
        if (cyc == 0) cyc = 1;
        return int'(cyc);
    endfunction

endpackage

// File: rtl/rst_sync2.sv
// Module: rst_sync2
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Each bit has its own reset value, taken from RST_VAL.
// Assumes: the bits are unrelated, so no bus coherence is needed.
module rst_sync2 #(
    parameter int unsigned    W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic [W-1:0]  d_async,
    output logic [W-1:0]  q_sync
);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic stage1;
            logic stage2;

            // Two-stage capture of one asynchronous bit
            always_ff @(posedge clk) begin
                if (!por_n) begin
                    stage1 <= RST_VAL[gi];
                    stage2 <= RST_VAL[gi];
                end else begin
                    stage1 <= d_async[gi];
                    stage2 <= stage1;
                end
            end

            assign q_sync[gi] = stage2;
        end
    endgenerate

endmodule

// File: rtl/rst_mr_filter.sv
// Module: rst_mr_filter
// Glitch filter for the synchronized active-low manual reset.
// The filtered state flips only after the input has disagreed with it for
// MR_CYC consecutive cycles. One agreeing sample clears the count, so the
// filter behaves the same when it activates and when it releases.
// Assumes: mr_n_s is already synchronized to clk.
module rst_mr_filter #(
    parameter int unsigned MR_CYC = 500
) (
    input  logic clk,
    input  logic por_n,
    input  logic mr_n_s,
    output logic mr_active
);

    localparam int unsigned CW = (MR_CYC < 2) ? 1 : $clog2(MR_CYC);
    localparam logic [CW-1:0] LAST = CW'(MR_CYC - 1);

    logic [CW-1:0] agree_cnt;
    logic          differs;

    assign differs = (~mr_n_s) != mr_active;

    // Count consecutive disagreeing samples and flip the state at the threshold
    always_ff @(posedge clk) begin
        if (!por_n) begin
            agree_cnt <= '0;
            mr_active <= 1'b0;
        end else if (differs) begin
            if (agree_cnt == LAST) begin
                agree_cnt <= '0;
                mr_active <= ~mr_active;
            end else begin
                agree_cnt <= agree_cnt + 1'b1;
            end
        end else begin
            agree_cnt <= '0;
        end
    end

endmodule

// File: rtl/rst_hold_timer.sv
// Module: rst_hold_timer
// Reset stretcher. The counter reloads to HOLD_CYC in every cycle in which
// a cause is present, and it counts down once all causes are gone. Reset
// releases in the cycle the count runs out. A one-cycle pulse marks each
// release.
// Assumes: cause is a synchronous, already filtered signal.
module rst_hold_timer #(
    parameter int unsigned HOLD_CYC = 1000
) (
    input  logic clk,
    input  logic por_n,
    input  logic cause,
    output logic rst_hold,
    output logic release_pulse
);

    localparam int unsigned HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] FULL = HW'(HOLD_CYC);
    localparam logic [HW-1:0] ONE  = HW'(1);

    logic [HW-1:0] remain;
    logic          last_tick;

    assign last_tick = !cause && (remain <= ONE);

    // Load the counter on a cause, otherwise count down to release
    always_ff @(posedge clk) begin
        if (!por_n) begin
            remain   <= FULL;
            rst_hold <= 1'b1;
        end else if (cause) begin
            remain   <= FULL;
            rst_hold <= 1'b1;
        end else if (!last_tick) begin
            remain   <= remain - 1'b1;
            rst_hold <= 1'b1;
        end else begin
            remain   <= '0;
            rst_hold <= 1'b0;
        end
    end

    // Flag the single cycle in which reset first reads released
    always_ff @(posedge clk) begin
        if (!por_n) release_pulse <= 1'b0;
        else        release_pulse <= rst_hold && last_tick;
    end

endmodule

// File: rtl/rst_supervisor.sv
// Module: rst_supervisor (top)
// Merges the supply-good flag and the filtered manual reset into one
// stretched reset, and drives it at the polarity set by OUT_ACTIVE_HIGH.
// Assumes: supply_ok and mr_n are asynchronous; por_n is synchronous to clk
// and is asserted once at power-on.
module rst_supervisor #(
    parameter int unsigned CLK_HZ          = 50_000_000,
    parameter int unsigned HOLD_US         = 240_000,
    parameter int unsigned MR_FILTER_NS    = 10_000,
    parameter bit          OUT_ACTIVE_HIGH = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok,
    input  logic mr_n,
    output logic rst_out,
    output logic rst_release
);

    localparam int unsigned HOLD_CYC =
        rst_supervisor_pkg::ns_to_cycles(longint'(CLK_HZ), longint'(HOLD_US) * 64'd1000);
    localparam int unsigned MR_CYC =
        rst_supervisor_pkg::ns_to_cycles(longint'(CLK_HZ), longint'(MR_FILTER_NS));

    logic [1:0] sync_q;
    logic       supply_ok_s;
    logic       mr_n_s;
    logic       mr_active;
    logic       rst_cause;
    logic       rst_hold;

    rst_sync2 #(.W(2), .RST_VAL(2'b10)) u_sync (
        .clk     (clk),
        .por_n   (por_n),
        .d_async ({mr_n, supply_ok}),
        .q_sync  (sync_q)
    );

    assign supply_ok_s = sync_q[0];
    assign mr_n_s      = sync_q[1];

    rst_mr_filter #(.MR_CYC(MR_CYC)) u_filt (
        .clk       (clk),
        .por_n     (por_n),
        .mr_n_s    (mr_n_s),
        .mr_active (mr_active)
    );

    assign rst_cause = !supply_ok_s || mr_active;

    rst_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk           (clk),
        .por_n         (por_n),
        .cause         (rst_cause),
        .rst_hold      (rst_hold),
        .release_pulse (rst_release)
    );

    // Polarity choice for the outgoing reset
    generate
        if (OUT_ACTIVE_HIGH) begin : g_pol_hi
            assign rst_out = rst_hold;
        end else begin : g_pol_lo
            assign rst_out = !rst_hold;
        end
    endgenerate

endmodule

// File: rtl/rst_supervisor_checker.sv
// Module: rst_supervisor_checker
// Temporal checks on the supervisor's internal hand-offs, attached by bind.
// Assumes: por_n is held low across at least one edge at start-up.
module rst_supervisor_checker (
    input logic clk,
    input logic por_n,
    input logic supply_s,
    input logic mr_s,
    input logic mr_act,
    input logic cause,
    input logic rst_q,
    input logic pulse
);

    // R1: a bad synchronized supply holds reset in the next cycle
    a_r1_supply_bad_holds: assert property (@(posedge clk) disable iff (!por_n)
        !supply_s |=> rst_q);

    // R2: an active filtered manual reset holds reset in the next cycle
    a_r2_mr_holds: assert property (@(posedge clk) disable iff (!por_n)
        mr_act |=> rst_q);

    // R3: reset never releases in a cycle that directly follows a cause
    a_r3_no_release_after_cause: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_q) |-> !$past(cause));

    // R7: the filter activates only after the synchronized line was low
    a_r7_filter_needs_low: assert property (@(posedge clk) disable iff (!por_n)
        $rose(mr_act) |-> !$past(mr_s));

    // R9: the release pulse lasts one cycle
    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!por_n)
        pulse |=> !pulse);

    // R9: the release pulse lines up with the fall of the hold register
    a_r9_pulse_on_release: assert property (@(posedge clk) disable iff (!por_n)
        pulse |-> (!rst_q && $past(rst_q)));

endmodule

bind rst_supervisor rst_supervisor_checker u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .supply_s (supply_ok_s),
    .mr_s     (mr_n_s),
    .mr_act   (mr_active),
    .cause    (rst_cause),
    .rst_q    (rst_hold),
    .pulse    (rst_release)
);

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
// Directed bench for rst_supervisor. Each scenario task checks its own
// results. Inputs change on falling edges and outputs are sampled there.
module tb_rst_supervisor;

    localparam int HOLD = 200;   // 1 us at 200 MHz
    localparam int MRC  = 20;    // 100 ns at 200 MHz
    localparam int LIM  = 2000;

    logic clk = 1'b0;
    logic por_n, supply_ok, mr_n;
    logic rst_lo, rel_lo, rst_hi, rel_hi;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    rst_supervisor #(.CLK_HZ(200_000_000), .HOLD_US(1), .MR_FILTER_NS(100),
                     .OUT_ACTIVE_HIGH(1'b0)) dut (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .mr_n(mr_n),
        .rst_out(rst_lo), .rst_release(rel_lo));

    rst_supervisor #(.CLK_HZ(200_000_000), .HOLD_US(1), .MR_FILTER_NS(100),
                     .OUT_ACTIVE_HIGH(1'b1)) dut_hi (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .mr_n(mr_n),
        .rst_out(rst_hi), .rst_release(rel_hi));

    function automatic logic in_reset();
        return !rst_lo;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges after a drive until reset reaches the wanted state
    task automatic count_until(input logic want, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (in_reset() != want && n < LIM);
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic t_reset_state();
        por_n = 1'b0; supply_ok = 1'b0; mr_n = 1'b1;
        idle(5);
        check(rst_lo == 1'b0, "R4 reset state low-active", rst_lo, 0);
        check(rst_hi == 1'b1, "R8 reset state high-active", rst_hi, 1);
        check(rel_lo == 1'b0, "R9 no pulse in reset", rel_lo, 0);
    endtask

    task automatic t_powerup_late();
        int n;
        por_n = 1'b1;
        idle(12);
        check(in_reset(), "R1 held while supply low", rst_lo, 0);
        supply_ok = 1'b1;
        count_until(1'b0, n);
        check(n == HOLD + 2, "R3 hold length on power-up", n, HOLD + 2);
        check(rel_lo == 1'b1 && rel_hi == 1'b1, "R9 pulse at release", rel_lo, 1);
        check(rst_hi == 1'b0, "R8 high-active released", rst_hi, 0);
        @(negedge clk);
        check(rel_lo == 1'b0, "R9 pulse one cycle", rel_lo, 0);
    endtask

    task automatic t_powerup_early();
        int n;
        por_n = 1'b0;
        idle(4);
        check(in_reset() && rst_hi, "R4 reasserted by por_n", rst_lo, 0);
        por_n = 1'b1;
        count_until(1'b0, n);
        check(n == HOLD + 2, "R4 full hold after por_n with supply good", n, HOLD + 2);
    endtask

    task automatic t_brownout();
        int n;
        supply_ok = 1'b0;
        count_until(1'b1, n);
        check(n == 3, "R1 brownout latency", n, 3);
        check(rst_hi == 1'b1, "R8 high-active asserted", rst_hi, 1);
        idle(7);
        supply_ok = 1'b1;
        count_until(1'b0, n);
        check(n == HOLD + 2, "R3 hold after brownout", n, HOLD + 2);
    endtask

    task automatic t_restart();
        int n;
        supply_ok = 1'b0; idle(3);
        supply_ok = 1'b1; idle(50);
        check(in_reset(), "R5 still holding mid-count", rst_lo, 0);
        supply_ok = 1'b0; idle(2);
        supply_ok = 1'b1;
        count_until(1'b0, n);
        check(n == HOLD + 2, "R5 full reload on second dip", n, HOLD + 2);
    endtask

    task automatic t_mr_glitch();
        int seen = 0;
        mr_n = 1'b0;
        repeat (MRC - 1) @(negedge clk);
        mr_n = 1'b1;
        for (int i = 0; i < MRC + 10; i++) begin
            @(negedge clk);
            if (in_reset()) seen++;
        end
        check(seen == 0, "R6 short manual pulse ignored", seen, 0);
    endtask

    task automatic t_mr_accept_and_hold();
        int n;
        int drop = 0;
        mr_n = 1'b0;
        count_until(1'b1, n);
        check(n == MRC + 3, "R7 manual accept latency", n, MRC + 3);
        for (int i = 0; i < HOLD + 100; i++) begin
            @(negedge clk);
            if (!in_reset()) drop++;
        end
        check(drop == 0, "R2 held while manual active", drop, 0);
        mr_n = 1'b1;
        count_until(1'b0, n);
        check(n == MRC + HOLD + 2, "R7 release after filter and hold", n, MRC + HOLD + 2);
    endtask

    task automatic t_mr_release_bounce();
        int n;
        int drop = 0;
        mr_n = 1'b0;
        count_until(1'b1, n);
        mr_n = 1'b1;
        repeat (MRC - 1) @(negedge clk);
        mr_n = 1'b0;
        idle(5);
        mr_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!in_reset() && n < MRC + HOLD + 2) drop++;
        end while (in_reset() && n < LIM);
        check(drop == 0, "R7 bounce keeps filter active", drop, 0);
        check(n == MRC + HOLD + 2, "R7 release count restarts", n, MRC + HOLD + 2);
    endtask

    task automatic t_mr_unused();
        int seen = 0;
        mr_n = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (in_reset() || rst_hi) seen++;
        end
        check(seen == 0, "R10 idle manual line never resets", seen, 0);
    endtask

    initial begin
        t_reset_state();
        t_powerup_late();
        t_mr_unused();
        t_powerup_early();
        t_brownout();
        t_restart();
        t_mr_glitch();
        t_mr_accept_and_hold();
        t_mr_release_bounce();
        t_mr_unused();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule